// File: doc/BRIEF.md
# Shared Two-Way Endpoint Packet Buffer

This block holds the packet storage of a single endpoint. One RAM region of `DEPTH` bytes is shared by a transmit FIFO and a receive FIFO. The transmit (IN) FIFO fills from the top address downward. The receive (OUT) FIFO fills from address zero upward. Firmware sets a maximum packet size for each direction. A combinational check raises a configuration error when the two sizes together exceed the region. Each direction can be set to isochronous or to bulk/interrupt. Bulk and interrupt behave identically.

On the transmit side, firmware loads bytes and then commits the packet. The bus side streams the bytes out. After a bulk send, the bus side either rewinds for a retry or releases the packet on a host handshake. An isochronous send is released as soon as it is sent. On the receive side, the bus side writes bytes and marks the packet complete. A handshake pulse follows only for bulk. Firmware unloads the bytes and clears the packet. Each direction keeps its own pointer and count. Writes beyond the configured maximum are dropped and set a sticky overrun flag.

Top module: `ep_shared_buf`

## Requirements
- R1: After reset, both ready flags, both counts, both overrun flags, the zero-length indication and the receive handshake output are 0.
- R2: The n-th transmit byte loaded by firmware (n from 0) is stored at address DEPTH-1-n. The bus side reads the bytes in loading order through `bus_in_data_o`, and each `bus_in_re_i` advances to the next byte.
- R3: The n-th receive byte written by the bus side is stored at address n. Firmware reads the bytes in order through `fw_out_data_o`, and each `fw_out_re_i` advances to the next byte.
- R4: `cfg_err_o` is 1 exactly when `cfg_in_max_i + cfg_out_max_i > DEPTH`.
- R5: A transmit byte write is not stored when the transmit count already equals `cfg_in_max_i`. Instead, `in_ovr_o` is set, and it stays set until the packet is released.
- R6: A receive byte write is not stored when the receive count already equals `cfg_out_max_i`. Instead, `out_ovr_o` is set, and it stays set until firmware clears the packet.
- R7: `fw_in_commit_i` sets `in_rdy_o`. While `in_rdy_o` is 1, firmware byte writes are ignored and the count does not change.
- R8: `bus_out_done_i` sets `out_rdy_o`. While `out_rdy_o` is 1, bus byte writes are ignored.
- R9: `fw_out_clr_i` clears `out_rdy_o`, the receive count, the read position and `out_ovr_o`.
- R10: In bulk transmit mode (`cfg_in_iso_i`=0), `bus_in_done_i` rewinds the read position to the first byte and keeps `in_rdy_o` at 1. `bus_in_ack_i` clears `in_rdy_o`, the count and `in_ovr_o`.
- R11: In isochronous transmit mode, `bus_in_done_i` clears `in_rdy_o` and the count, with no handshake required.
- R12: In the cycle after `bus_out_done_i` completes a receive packet, `bus_out_ack_o` is 1 for exactly one cycle in bulk mode and stays 0 in isochronous mode.
- R13: `bus_in_zlp_o` is 1 exactly when `in_rdy_o` is 1 and the transmit count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_in_max_i | input | CW | Transmit maximum packet size |
| cfg_out_max_i | input | CW | Receive maximum packet size |
| cfg_in_iso_i | input | 1 | Transmit direction is isochronous |
| cfg_out_iso_i | input | 1 | Receive direction is isochronous |
| cfg_err_o | output | 1 | Sum of the maximum sizes exceeds the region |
| fw_in_we_i | input | 1 | Firmware transmit byte write |
| fw_in_data_i | input | DW | Firmware transmit byte |
| fw_in_commit_i | input | 1 | Firmware marks the transmit packet ready |
| fw_out_re_i | input | 1 | Firmware advances the receive read position |
| fw_out_clr_i | input | 1 | Firmware releases the receive packet |
| fw_out_data_o | output | DW | Receive byte at the read position |
| bus_in_re_i | input | 1 | Bus advances the transmit read position |
| bus_in_done_i | input | 1 | Transmit packet has been sent |
| bus_in_ack_i | input | 1 | Host handshake for the transmit packet |
| bus_in_data_o | output | DW | Transmit byte at the read position |
| bus_in_zlp_o | output | 1 | Ready transmit packet has zero length |
| bus_out_we_i | input | 1 | Bus receive byte write |
| bus_out_data_i | input | DW | Bus receive byte |
| bus_out_done_i | input | 1 | Receive packet complete |
| bus_out_ack_o | output | 1 | Handshake pulse for a bulk receive packet |
| in_rdy_o | output | 1 | Transmit packet ready |
| in_cnt_o | output | CW | Transmit byte count |
| in_ovr_o | output | 1 | Transmit overrun |
| out_rdy_o | output | 1 | Receive packet ready |
| out_cnt_o | output | CW | Receive byte count |
| out_ovr_o | output | 1 | Receive overrun |

## Verification
The size check is driven from a table of size pairs. The table includes sums that sit exactly on the region size and sums one byte over it. A short packet is used to separate the bulk rewind from the isochronous release. An empty committed packet exposes the zero-length indication, and oversized packets expose truncation and the overrun flags. An oversized configuration is then used on purpose so that both FIFOs fill the whole region. Transmit bytes then overwrite the top receive bytes, which shows the opposite fill directions and the exact address of each byte.

// File: rtl/sebuf_pkg.sv
package sebuf_pkg;
  // true when the two packet sizes cannot share the region
  function automatic logic sizes_clash(int unsigned in_max, int unsigned out_max,
                                       int unsigned depth);
    return (in_max + out_max) > depth;
  endfunction
endpackage

// File: rtl/sebuf_mem.sv
module sebuf_mem #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wa_we_i,
  input  logic [AW-1:0] wa_addr_i,
  input  logic [DW-1:0] wa_data_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // port a wins on a shared address (only possible with a bad config)
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (wa_we_i && wa_addr_i == AW'(i))      mem_q[i] <= wa_data_i;
      else if (wb_we_i && wb_addr_i == AW'(i)) mem_q[i] <= wb_data_i;
    end
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/sebuf_in_ctrl.sv
module sebuf_in_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] max_i,
  input  logic          iso_i,
  input  logic          wr_i,
  input  logic          commit_i,
  input  logic          rd_i,
  input  logic          done_i,
  input  logic          ack_i,
  output logic          rdy_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovr_o,
  output logic          zlp_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [AW-1:0] mem_raddr_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, rptr_q;
  logic          rdy_q, ovr_q;
  logic          accept, drop, release_pkt, rewind;

  assign accept      = wr_i && !rdy_q && (cnt_q < max_i);
  assign drop        = wr_i && !rdy_q && (cnt_q >= max_i);
  assign release_pkt = rdy_q && (iso_i ? done_i : ack_i);
  assign rewind      = rdy_q && !iso_i && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rptr_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (release_pkt) begin
      cnt_q  <= '0;
      rptr_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept)              cnt_q <= cnt_q + CW'(1);
      if (drop)                ovr_q <= 1'b1;
      if (commit_i && !rdy_q)  rdy_q <= 1'b1;
      if (rewind)                                rptr_q <= '0;
      else if (rd_i && rdy_q && rptr_q < cnt_q)  rptr_q <= rptr_q + CW'(1);
    end
  end

  // top-down placement
  assign mem_we_o    = accept;
  assign mem_waddr_o = TOP - cnt_q[AW-1:0];
  assign mem_raddr_o = TOP - rptr_q[AW-1:0];
  assign rdy_o       = rdy_q;
  assign cnt_o       = cnt_q;
  assign ovr_o       = ovr_q;
  assign zlp_o       = rdy_q && (cnt_q == '0);

  a_r7_frozen_while_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q && !release_pkt |=> $stable(cnt_q) && rdy_q);
  a_r5_drop_flags_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop && !release_pkt |=> ovr_q && $stable(cnt_q));
  a_r10_bulk_done_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind && !ack_i |=> rdy_q && rptr_q == '0);
  a_r11_iso_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q && iso_i && done_i |=> !rdy_q && cnt_q == '0);
endmodule

// File: rtl/sebuf_out_ctrl.sv
module sebuf_out_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] max_i,
  input  logic          iso_i,
  input  logic          wr_i,
  input  logic          done_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic          rdy_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovr_o,
  output logic          ack_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [AW-1:0] mem_raddr_o
);
  logic [CW-1:0] cnt_q, rptr_q;
  logic          rdy_q, ovr_q, ack_q;
  logic          accept, drop, complete, clear;

  assign accept   = wr_i && !rdy_q && (cnt_q < max_i);
  assign drop     = wr_i && !rdy_q && (cnt_q >= max_i);
  assign complete = done_i && !rdy_q;
  assign clear    = clr_i && rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rptr_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= complete && !iso_i;
      if (clear) begin
        cnt_q  <= '0;
        rptr_q <= '0;
        rdy_q  <= 1'b0;
        ovr_q  <= 1'b0;
      end else begin
        if (accept)   cnt_q <= cnt_q + CW'(1);
        if (drop)     ovr_q <= 1'b1;
        if (complete) rdy_q <= 1'b1;
        if (rd_i && rdy_q && rptr_q < cnt_q) rptr_q <= rptr_q + CW'(1);
      end
    end
  end

  // bottom-up placement
  assign mem_we_o    = accept;
  assign mem_waddr_o = cnt_q[AW-1:0];
  assign mem_raddr_o = rptr_q[AW-1:0];
  assign rdy_o       = rdy_q;
  assign cnt_o       = cnt_q;
  assign ovr_o       = ovr_q;
  assign ack_o       = ack_q;

  a_r8_bus_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q && !clr_i |=> $stable(cnt_q) && rdy_q);
  a_r12_ack_bulk_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(done_i && !iso_i));
  a_r12_ack_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> !rdy_q && cnt_q == '0 && !ovr_q);
  a_r6_drop_flags_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ovr_q && $stable(cnt_q));
endmodule

// File: rtl/ep_shared_buf.sv
module ep_shared_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cfg_in_max_i,
  input  logic [CW-1:0] cfg_out_max_i,
  input  logic          cfg_in_iso_i,
  input  logic          cfg_out_iso_i,
  output logic          cfg_err_o,
  input  logic          fw_in_we_i,
  input  logic [DW-1:0] fw_in_data_i,
  input  logic          fw_in_commit_i,
  input  logic          fw_out_re_i,
  input  logic          fw_out_clr_i,
  output logic [DW-1:0] fw_out_data_o,
  input  logic          bus_in_re_i,
  input  logic          bus_in_done_i,
  input  logic          bus_in_ack_i,
  output logic [DW-1:0] bus_in_data_o,
  output logic          bus_in_zlp_o,
  input  logic          bus_out_we_i,
  input  logic [DW-1:0] bus_out_data_i,
  input  logic          bus_out_done_i,
  output logic          bus_out_ack_o,
  output logic          in_rdy_o,
  output logic [CW-1:0] in_cnt_o,
  output logic          in_ovr_o,
  output logic          out_rdy_o,
  output logic [CW-1:0] out_cnt_o,
  output logic          out_ovr_o
);
  import sebuf_pkg::*;

  logic          in_we, out_we;
  logic [AW-1:0] in_waddr, in_raddr, out_waddr, out_raddr;

  assign cfg_err_o = sizes_clash(32'(cfg_in_max_i), 32'(cfg_out_max_i), DEPTH);

  sebuf_in_ctrl #(.DEPTH(DEPTH)) u_in (
    .clk_i, .rst_ni,
    .max_i(cfg_in_max_i), .iso_i(cfg_in_iso_i),
    .wr_i(fw_in_we_i), .commit_i(fw_in_commit_i),
    .rd_i(bus_in_re_i), .done_i(bus_in_done_i), .ack_i(bus_in_ack_i),
    .rdy_o(in_rdy_o), .cnt_o(in_cnt_o), .ovr_o(in_ovr_o), .zlp_o(bus_in_zlp_o),
    .mem_we_o(in_we), .mem_waddr_o(in_waddr), .mem_raddr_o(in_raddr)
  );

  sebuf_out_ctrl #(.DEPTH(DEPTH)) u_out (
    .clk_i, .rst_ni,
    .max_i(cfg_out_max_i), .iso_i(cfg_out_iso_i),
    .wr_i(bus_out_we_i), .done_i(bus_out_done_i),
    .rd_i(fw_out_re_i), .clr_i(fw_out_clr_i),
    .rdy_o(out_rdy_o), .cnt_o(out_cnt_o), .ovr_o(out_ovr_o), .ack_o(bus_out_ack_o),
    .mem_we_o(out_we), .mem_waddr_o(out_waddr), .mem_raddr_o(out_raddr)
  );

  sebuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i,
    .wa_we_i(in_we),  .wa_addr_i(in_waddr),  .wa_data_i(fw_in_data_i),
    .wb_we_i(out_we), .wb_addr_i(out_waddr), .wb_data_i(bus_out_data_i),
    .ra_addr_i(in_raddr),  .ra_data_o(bus_in_data_o),
    .rb_addr_i(out_raddr), .rb_data_o(fw_out_data_o)
  );

  a_r13_zlp_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_in_zlp_o |-> in_rdy_o && in_cnt_o == '0);
  a_r5_in_within_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(in_cnt_o) && in_cnt_o != '0 |-> in_cnt_o <= cfg_in_max_i || !$stable(cfg_in_max_i));
endmodule

// File: tb/sim_ep_shared_buf.sv
`timescale 1ns/1ps
module sim_ep_shared_buf;
  localparam int DEPTH = 32;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic [CW-1:0] cfg_in_max = 16, cfg_out_max = 16;
  logic cfg_in_iso = 0, cfg_out_iso = 0, cfg_err;
  logic fw_in_we = 0, fw_in_commit = 0, fw_out_re = 0, fw_out_clr = 0;
  logic [DW-1:0] fw_in_data = 0, fw_out_data, bus_in_data, bus_out_data = 0;
  logic bus_in_re = 0, bus_in_done = 0, bus_in_ack = 0, bus_in_zlp;
  logic bus_out_we = 0, bus_out_done = 0, bus_out_ack;
  logic in_rdy, in_ovr, out_rdy, out_ovr;
  logic [CW-1:0] in_cnt, out_cnt;

  ep_shared_buf #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni,
    .cfg_in_max_i(cfg_in_max), .cfg_out_max_i(cfg_out_max),
    .cfg_in_iso_i(cfg_in_iso), .cfg_out_iso_i(cfg_out_iso), .cfg_err_o(cfg_err),
    .fw_in_we_i(fw_in_we), .fw_in_data_i(fw_in_data), .fw_in_commit_i(fw_in_commit),
    .fw_out_re_i(fw_out_re), .fw_out_clr_i(fw_out_clr), .fw_out_data_o(fw_out_data),
    .bus_in_re_i(bus_in_re), .bus_in_done_i(bus_in_done), .bus_in_ack_i(bus_in_ack),
    .bus_in_data_o(bus_in_data), .bus_in_zlp_o(bus_in_zlp),
    .bus_out_we_i(bus_out_we), .bus_out_data_i(bus_out_data),
    .bus_out_done_i(bus_out_done), .bus_out_ack_o(bus_out_ack),
    .in_rdy_o(in_rdy), .in_cnt_o(in_cnt), .in_ovr_o(in_ovr),
    .out_rdy_o(out_rdy), .out_cnt_o(out_cnt), .out_ovr_o(out_ovr)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic in_wr(int d);
    fw_in_we = 1; fw_in_data = DW'(d); step(); fw_in_we = 0;
  endtask

  task automatic out_wr(int d);
    bus_out_we = 1; bus_out_data = DW'(d); step(); bus_out_we = 0;
  endtask

  task automatic pulse_commit(); fw_in_commit = 1; step(); fw_in_commit = 0; endtask
  task automatic pulse_in_done(); bus_in_done = 1; step(); bus_in_done = 0; endtask
  task automatic pulse_in_ack();  bus_in_ack = 1; step(); bus_in_ack = 0; endtask
  task automatic pulse_in_re();   bus_in_re = 1; step(); bus_in_re = 0; endtask
  task automatic pulse_out_done(); bus_out_done = 1; step(); bus_out_done = 0; endtask
  task automatic pulse_out_re();  fw_out_re = 1; step(); fw_out_re = 0; endtask
  task automatic pulse_out_clr(); fw_out_clr = 1; step(); fw_out_clr = 0; endtask

  // {in_max, out_max, expected cfg_err}
  localparam int VEC [8][3] = '{
    '{16, 16, 0}, '{32, 0, 0}, '{0, 32, 0}, '{17, 16, 1},
    '{32, 1, 1},  '{20, 10, 0}, '{31, 1, 0}, '{32, 32, 1}
  };

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 in_rdy", in_rdy, 0);       chk("R1 out_rdy", out_rdy, 0);
    chk("R1 in_cnt", in_cnt, 0);       chk("R1 out_cnt", out_cnt, 0);
    chk("R1 ovr", in_ovr | out_ovr, 0); chk("R1 zlp", bus_in_zlp, 0);
    chk("R1 ack", bus_out_ack, 0);
    rst_ni = 1; step();

    // R4 size-fit table
    for (int i = 0; i < 8; i++) begin
      cfg_in_max = CW'(VEC[i][0]); cfg_out_max = CW'(VEC[i][1]); #1;
      chk("R4 cfg_err", cfg_err, VEC[i][2]);
    end
    cfg_in_max = 16; cfg_out_max = 16; step();

    // R2 / R7 transmit load and stream
    in_wr(8'hA0); in_wr(8'hA1); in_wr(8'hA2);
    chk("R2 in_cnt", in_cnt, 3);
    pulse_commit();
    chk("R7 in_rdy set", in_rdy, 1);
    in_wr(8'hFF);
    chk("R7 write ignored", in_cnt, 3);
    chk("R13 no zlp with data", bus_in_zlp, 0);
    chk("R2 byte0", bus_in_data, 8'hA0);
    pulse_in_re(); chk("R2 byte1", bus_in_data, 8'hA1);
    pulse_in_re(); chk("R2 byte2", bus_in_data, 8'hA2);
    // R10 bulk rewind then ack
    pulse_in_done();
    chk("R10 rdy kept", in_rdy, 1);
    chk("R10 rewind", bus_in_data, 8'hA0);
    pulse_in_ack();
    chk("R10 ack clears rdy", in_rdy, 0);
    chk("R10 ack clears cnt", in_cnt, 0);

    // R13 zero-length packet
    pulse_commit();
    chk("R13 zlp", bus_in_zlp, 1);
    pulse_in_ack();
    chk("R13 zlp gone", bus_in_zlp, 0);

    // R11 isochronous transmit
    cfg_in_iso = 1;
    in_wr(8'h11); pulse_commit();
    pulse_in_done();
    chk("R11 iso done clears rdy", in_rdy, 0);
    chk("R11 iso done clears cnt", in_cnt, 0);
    cfg_in_iso = 0;

    // R5 transmit truncation
    cfg_in_max = 4;
    for (int i = 0; i < 6; i++) in_wr(8'hC0 + i);
    chk("R5 cnt capped", in_cnt, 4);
    chk("R5 ovr set", in_ovr, 1);
    pulse_commit();
    pulse_in_re(); pulse_in_re(); pulse_in_re();
    chk("R5 last kept byte", bus_in_data, 8'hC3);
    pulse_in_ack();
    chk("R5 ovr cleared", in_ovr, 0);
    cfg_in_max = 16;

    // R3 / R8 / R12 bulk receive
    out_wr(8'hB0); out_wr(8'hB1); out_wr(8'hB2);
    chk("R3 out_cnt", out_cnt, 3);
    chk("R8 not ready yet", out_rdy, 0);
    pulse_out_done();
    chk("R8 out_rdy", out_rdy, 1);
    chk("R12 bulk ack", bus_out_ack, 1);
    out_wr(8'hEE);
    chk("R12 ack one cycle", bus_out_ack, 0);
    chk("R8 write ignored", out_cnt, 3);
    chk("R3 byte0", fw_out_data, 8'hB0);
    pulse_out_re(); chk("R3 byte1", fw_out_data, 8'hB1);
    pulse_out_re(); chk("R3 byte2", fw_out_data, 8'hB2);
    pulse_out_clr();
    chk("R9 rdy cleared", out_rdy, 0);
    chk("R9 cnt cleared", out_cnt, 0);

    // R12 isochronous receive: no handshake
    cfg_out_iso = 1;
    out_wr(8'h22);
    pulse_out_done();
    chk("R12 iso rdy", out_rdy, 1);
    chk("R12 iso no ack", bus_out_ack, 0);
    step();
    chk("R12 iso still no ack", bus_out_ack, 0);
    pulse_out_clr();
    cfg_out_iso = 0;

    // R6 receive truncation, R9 clears overrun
    cfg_out_max = 2;
    out_wr(1); out_wr(2); out_wr(3);
    chk("R6 cnt capped", out_cnt, 2);
    chk("R6 ovr set", out_ovr, 1);
    pulse_out_done(); pulse_out_clr();
    chk("R9 ovr cleared", out_ovr, 0);

    // R2 / R3 placement: overlapping config, transmit overwrites top
    cfg_in_max = 32; cfg_out_max = 32; #1;
    chk("R4 overlap flagged", cfg_err, 1);
    for (int i = 0; i < DEPTH; i++) out_wr(8'h40 + i);
    chk("R3 full count", out_cnt, DEPTH);
    in_wr(8'h99); in_wr(8'h98);
    pulse_out_done();
    chk("R3 addr0", fw_out_data, 8'h40);
    for (int i = 0; i < 29; i++) pulse_out_re();
    chk("R3 addr29 intact", fw_out_data, 8'h40 + 29);
    pulse_out_re();
    chk("R2 in byte1 at addr30", fw_out_data, 8'h98);
    pulse_out_re();
    chk("R2 in byte0 at top", fw_out_data, 8'h99);
    pulse_commit();
    chk("R2 stream top first", bus_in_data, 8'h99);
    pulse_in_re();
    chk("R2 stream next lower", bus_in_data, 8'h98);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule